// File: doc/BRIEF.md
# Two-World Banked Down-Counter Timer

A down-counting timer on an AXI4-Lite slave port that serves the secure and the non-secure software world at the same time. Each access carries its world in bit 1 of the protection field (`s_awprot`/`s_arprot`, 1 = non-secure). The two worlds use the same four word offsets. Each world reaches its own reload value, its own running count and its own enable and auto-reload bits. The tick divider and the two interrupt enables are shared, and only secure writes can change them. Each world has its own interrupt line. The non-secure count drives `irq`, and the secure count drives `fiq`.

Both channels use valid/ready handshakes. A write is taken in the cycle where `s_awvalid` and `s_wvalid` are both high and no write response is pending. `s_awready` and `s_wready` rise together in that cycle. The response then holds in `s_bvalid` until `s_bready` is sampled high, and the next write waits until it is released. A read address is taken while no read data is pending. `s_rdata` stays frozen with `s_rvalid` until `s_rready` is sampled high. Every response is OKAY.

Word map (address bits 3:2): 0 control, 1 reload, 2 count, 3 event flags.

Top module: `banked_timer`

## Requirements
- R1: A write is accepted when both write valids are high and `s_bvalid` is low. A read is accepted when `s_arvalid` is high and `s_rvalid` is low. `s_bvalid` and `s_rvalid` each rise in the cycle after acceptance and hold until their ready is high. `s_rdata` is stable while held. `s_bresp` and `s_rresp` are always 2'b00.
- R2: After reset every register reads zero. At words 1 and 2, each world reads and writes only its own reload and count. Activity from one world leaves the other world's values untouched.
- R3: Writing word 1 sets the world's reload value and also its count. Writing word 2 sets only the count.
- R4: Control bit 0 (run) and bit 1 (auto-reload) are held separately for each world. Each world reads back and changes only its own pair.
- R5: Control bits 15:8 (tick divider), bit 2 (FIQ enable) and bit 3 (IRQ enable) change only on secure writes. Non-secure writes leave them unchanged, and non-secure reads return zero in those positions.
- R6: A free-running divider produces one tick every divider+1 clocks. While its run bit is set and its count is nonzero, a count drops by one on each tick. With the run bit clear, the count holds.
- R7: When a count steps from 1 to 0, the world's event flag sets. With auto-reload set, the count takes the reload value instead of 0. Otherwise it rests at 0.
- R8: Flag word bit 0 is the secure event and bit 1 is the non-secure event. Writing 1 clears a flag. Non-secure writes can clear only bit 1, and non-secure reads see bit 0 as zero. A set in the same cycle wins over a clear.
- R9: `irq` is high exactly while flag bit 1 and the IRQ enable are both set. `fiq` is high exactly while flag bit 0 and the FIQ enable are both set.
- R10: Only the byte lanes whose `s_wstrb` bit is set are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awprot | input | 3 | Write protection, bit 1 = non-secure |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arprot | input | 3 | Read protection, bit 1 = non-secure |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| irq | output | 1 | Non-secure world interrupt |
| fiq | output | 1 | Secure world interrupt |

## Verification
The assertions check several rules on every cycle: the response holds under back-pressure, and a non-secure write never moves the shared divider, the interrupt enables or the secure flag. They also check that a load write makes the count equal the reload value, that a stopped count stays still, that a one-shot count rests at zero, and that divider ticks are spaced correctly. Some behaviour can only be shown through the bench's scenarios, checked against its cycle-by-cycle model: which world's values a read returns, the exact cycle an event flag sets, set-over-clear ordering, byte-lane merging, and the reload period.

// File: rtl/bt_pkg.sv
package bt_pkg;
  // word offsets (address bits 3:2)
  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_LOAD = 2'd1;
  localparam logic [1:0] OFF_CNT  = 2'd2;
  localparam logic [1:0] OFF_STAT = 2'd3;
  // control bit positions
  localparam int B_RUN    = 0;
  localparam int B_AUTO   = 1;
  localparam int B_FIQEN  = 2;
  localparam int B_IRQEN  = 3;
  localparam int B_DIV_LO = 8;
  // world index: also the bank index and the flag bit
  typedef enum logic {W_SEC = 1'b0, W_NSEC = 1'b1} world_e;
  localparam logic [1:0] OKAY = 2'b00;
endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] acc;

  assign tick = (acc >= div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (tick) acc <= '0;
    else           acc <= acc + 1'b1;
  end

  // R6: with a nonzero, unchanged divider two ticks are never adjacent
  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && div_val != '0 && $stable(div_val) |=> !tick);
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             auto_rl,
  input  logic             ld_we,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step     = !ld_we && !cnt_we && run && tick && (cnt_q != '0);
  assign zero_hit = step && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
    end else if (ld_we) begin
      load_q <= wr_val;
      cnt_q  <= wr_val;
    end else if (cnt_we) begin
      cnt_q  <= wr_val;
    end else if (step) begin
      if (cnt_q == ONE) cnt_q <= auto_rl ? load_q : '0;
      else              cnt_q <= cnt_q - ONE;
    end
  end

  assert_load_sets_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> cnt_q == load_q);
  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !ld_we && !cnt_we |=> $stable(cnt_q));
  assert_oneshot_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit && !auto_rl |=> cnt_q == '0);
endmodule

// File: rtl/banked_timer.sv
module banked_timer
  import bt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [2:0]          s_awprot,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [1:0]          s_bresp,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic [2:0]          s_arprot,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                irq,
  output logic                fiq
);
  localparam int STRB_W = DATA_W / 8;

  logic             wr_fire, rd_fire, tick;
  world_e           wr_w, rd_w;
  logic [1:0]       wr_sel, rd_sel, clr, hit;
  logic [1:0]       run_q, auto_q, flag_q;
  logic             fiq_en_q, irq_en_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0][CNT_W-1:0]  load_q, cnt_q;
  logic [1:0][DATA_W-1:0] ctrl_v, stat_v, load_v, cnt_v;
  logic [DATA_W-1:0] wr_old, wr_new, rd_view;
  logic unused_bits;

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old,
      input logic [DATA_W-1:0] nw, input logic [STRB_W-1:0] st);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < STRB_W; i++) r[8*i +: 8] = st[i] ? nw[8*i +: 8] : old[8*i +: 8];
    return r;
  endfunction

  assign unused_bits = ^{s_awaddr, s_araddr, s_awprot, s_arprot};

  // handshakes
  assign s_awready = s_awvalid & s_wvalid & ~s_bvalid;
  assign s_wready  = s_awready;
  assign wr_fire   = s_awready;
  assign s_arready = ~s_rvalid;
  assign rd_fire   = s_arvalid & s_arready;
  assign s_bresp   = OKAY;
  assign s_rresp   = OKAY;

  assign wr_w   = world_e'(s_awprot[1]);
  assign rd_w   = world_e'(s_arprot[1]);
  assign wr_sel = s_awaddr[3:2];
  assign rd_sel = s_araddr[3:2];

  bt_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_val(div_q), .tick(tick));

  // one bank per world; the view each world sees is built here too
  for (genvar w = 0; w < 2; w++) begin : g_bank
    logic ld_we, cnt_we;
    assign ld_we  = wr_fire && (wr_w == world_e'(w)) && (wr_sel == OFF_LOAD);
    assign cnt_we = wr_fire && (wr_w == world_e'(w)) && (wr_sel == OFF_CNT);

    bt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_q[w]), .auto_rl(auto_q[w]),
      .ld_we(ld_we), .cnt_we(cnt_we), .wr_val(wr_new[CNT_W-1:0]),
      .load_q(load_q[w]), .cnt_q(cnt_q[w]), .zero_hit(hit[w]));

    always_comb begin
      ctrl_v[w]         = '0;
      ctrl_v[w][B_RUN]  = run_q[w];
      ctrl_v[w][B_AUTO] = auto_q[w];
      stat_v[w]         = '0;
      stat_v[w][1]      = flag_q[1];
      if (w == 0) begin
        ctrl_v[w][B_FIQEN]              = fiq_en_q;
        ctrl_v[w][B_IRQEN]              = irq_en_q;
        ctrl_v[w][B_DIV_LO +: DIV_W]    = div_q;
        stat_v[w][0]                    = flag_q[0];
      end
      load_v[w] = DATA_W'(load_q[w]);
      cnt_v[w]  = DATA_W'(cnt_q[w]);
    end
  end

  always_comb begin
    unique case (wr_sel)
      OFF_CTRL: wr_old = ctrl_v[wr_w];
      OFF_LOAD: wr_old = load_v[wr_w];
      OFF_CNT:  wr_old = cnt_v[wr_w];
      default:  wr_old = stat_v[wr_w];
    endcase
    unique case (rd_sel)
      OFF_CTRL: rd_view = ctrl_v[rd_w];
      OFF_LOAD: rd_view = load_v[rd_w];
      OFF_CNT:  rd_view = cnt_v[rd_w];
      default:  rd_view = stat_v[rd_w];
    endcase
  end
  assign wr_new = lane_merge(wr_old, s_wdata, s_wstrb);

  // write-1-to-clear; a non-secure write reaches only its own flag
  assign clr = (wr_fire && wr_sel == OFF_STAT)
             ? (s_wdata[1:0] & {2{s_wstrb[0]}} & ((wr_w == W_NSEC) ? 2'b10 : 2'b11)) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0; auto_q <= '0; flag_q <= '0;
      fiq_en_q <= 1'b0; irq_en_q <= 1'b0; div_q <= '0;
      s_bvalid <= 1'b0; s_rvalid <= 1'b0; s_rdata <= '0;
    end else begin
      if (wr_fire && wr_sel == OFF_CTRL) begin
        run_q[wr_w]  <= wr_new[B_RUN];
        auto_q[wr_w] <= wr_new[B_AUTO];
        if (wr_w == W_SEC) begin
          fiq_en_q <= wr_new[B_FIQEN];
          irq_en_q <= wr_new[B_IRQEN];
          div_q    <= wr_new[B_DIV_LO +: DIV_W];
        end
      end
      flag_q <= (flag_q & ~clr) | hit;
      if (wr_fire)       s_bvalid <= 1'b1;
      else if (s_bready) s_bvalid <= 1'b0;
      if (rd_fire) begin
        s_rvalid <= 1'b1;
        s_rdata  <= rd_view;
      end else if (s_rready) begin
        s_rvalid <= 1'b0;
      end
    end
  end

  assign irq = flag_q[1] & irq_en_q;
  assign fiq = flag_q[0] & fiq_en_q;

  assert_bresp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);
  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  assert_ns_shared_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && wr_w == W_NSEC |=> $stable(div_q) && $stable(fiq_en_q) && $stable(irq_en_q));
  assert_ns_keeps_sec_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && wr_w == W_NSEC && flag_q[0] |=> flag_q[0]);
  assert_bank_isolation_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && wr_w == W_NSEC && !run_q[0] |=> $stable(cnt_q[0]) && $stable(load_q[0]));
endmodule

// File: tb/sim_banked_timer.sv
`timescale 1ns/1ps
module sim_banked_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [3:0] awaddr = 0, araddr = 0;
  logic [2:0] awprot = 0, arprot = 0;
  logic [31:0] wdata = 0;
  logic [3:0] wstrb = 0;
  logic awready, wready, bvalid, arready, rvalid, irq, fiq;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  int n_cmp = 0, n_bad = 0;
  string cur_req = "R2";

  always #4 clk = ~clk;

  banked_timer u0 (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr), .s_awprot(awprot),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr), .s_arprot(arprot),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .irq(irq), .fiq(fiq));

  // ---------------- reference model ----------------
  logic [31:0] m_ld [2];
  logic [31:0] m_cnt[2];
  logic [1:0]  m_run, m_auto, m_fl;
  logic        m_fe, m_ie, m_bv, m_rv;
  logic [7:0]  m_div;
  logic [31:0] m_rd;
  int          m_acc;

  function automatic logic [31:0] mg(logic [31:0] o, logic [31:0] n, logic [3:0] s);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = s[i] ? n[8*i +: 8] : o[8*i +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mview(logic [1:0] sel, logic ns);
    case (sel)
      2'd0: return ns ? {30'b0, m_auto[1], m_run[1]}
                      : {16'b0, m_div, 4'b0, m_ie, m_fe, m_auto[0], m_run[0]};
      2'd1: return m_ld[ns];
      2'd2: return m_cnt[ns];
      default: return ns ? {30'b0, m_fl[1], 1'b0} : {30'b0, m_fl};
    endcase
  endfunction

  always @(posedge clk) begin
    logic fire, tk;
    logic [31:0] nv;
    logic [1:0] hit, clr, sel;
    int w;
    if (!rst_n) begin
      m_ld[0] = 0; m_ld[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
      m_run = 0; m_auto = 0; m_fl = 0; m_fe = 0; m_ie = 0; m_div = 0;
      m_bv = 0; m_rv = 0; m_rd = 0; m_acc = 0;
    end else begin
      fire = awvalid && wvalid && !m_bv;
      w    = int'(awprot[1]);
      sel  = awaddr[3:2];
      nv   = mg(mview(sel, awprot[1]), wdata, wstrb);
      if (arvalid && !m_rv) begin m_rd = mview(araddr[3:2], arprot[1]); m_rv = 1; end
      else if (rready) m_rv = 0;
      tk  = (m_acc >= int'(m_div));
      hit = 0;
      for (int b = 0; b < 2; b++) begin
        if (fire && w == b && sel == 2'd1) begin m_ld[b] = nv; m_cnt[b] = nv; end
        else if (fire && w == b && sel == 2'd2) m_cnt[b] = nv;
        else if (m_run[b] && tk && m_cnt[b] != 0) begin
          if (m_cnt[b] == 1) begin hit[b] = 1; m_cnt[b] = m_auto[b] ? m_ld[b] : 0; end
          else m_cnt[b] = m_cnt[b] - 1;
        end
      end
      clr = 0;
      if (fire && sel == 2'd3 && wstrb[0]) clr = wdata[1:0] & (w == 1 ? 2'b10 : 2'b11);
      if (fire && sel == 2'd0) begin
        m_run[w] = nv[0]; m_auto[w] = nv[1];
        if (w == 0) begin m_fe = nv[2]; m_ie = nv[3]; m_div = nv[15:8]; end
      end
      m_acc = tk ? 0 : m_acc + 1;
      m_fl  = (m_fl & ~clr) | hit;
      if (fire) m_bv = 1; else if (bready) m_bv = 0;
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  // compared on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk("R9 irq", 32'(irq), 32'(m_fl[1] & m_ie));
    chk("R9 fiq", 32'(fiq), 32'(m_fl[0] & m_fe));
    chk("R1 bvalid", 32'(bvalid), 32'(m_bv));
    chk("R1 rvalid", 32'(rvalid), 32'(m_rv));
    if (bvalid) chk("R1 bresp", 32'(bresp), 32'd0);
    if (rvalid) begin
      chk("R1 rresp", 32'(rresp), 32'd0);
      chk({cur_req, " rdata"}, rdata, m_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic ns, int off, logic [31:0] d, logic [3:0] st = 4'hF);
    @(negedge clk);
    awvalid = 1; wvalid = 1; awaddr = 4'(off * 4); awprot = {1'b0, ns, 1'b0};
    wdata = d; wstrb = st;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
  endtask

  task automatic rd(logic ns, int off);
    @(negedge clk);
    arvalid = 1; araddr = 4'(off * 4); arprot = {1'b0, ns, 1'b0};
    @(negedge clk);
    arvalid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_all();
    for (int o = 0; o < 4; o++) begin rd(1'b0, o); rd(1'b1, o); end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1;
    cur_req = "R2"; rd_all();                       // reset state reads zero
    cur_req = "R3";
    wr(1'b0, 1, 32'd5); rd(1'b0, 2); rd(1'b0, 1);   // load writes count too
    wr(1'b1, 2, 32'd7); rd(1'b1, 2); rd(1'b1, 1);   // count write leaves load
    cur_req = "R2"; rd(1'b1, 1); rd(1'b0, 2);       // banks isolated
    cur_req = "R5"; wr(1'b1, 0, 32'hFFFF_FFFF);     // ns cannot touch shared fields
    rd(1'b0, 0); rd(1'b1, 0);
    cur_req = "R4"; rd(1'b0, 0);
    cur_req = "R7"; idle(12); rd(1'b1, 3); rd(1'b1, 2);
    cur_req = "R6"; wr(1'b0, 0, 32'h0000_020F);     // divider 2, both enables, run+auto
    rd(1'b0, 0); idle(20); rd(1'b0, 2); idle(17); rd(1'b0, 2);
    cur_req = "R8"; rd(1'b0, 3); rd(1'b1, 3);
    wr(1'b1, 3, 32'h3); rd(1'b0, 3);                // ns clears only bit 1
    wr(1'b0, 3, 32'h1); rd(1'b0, 3);
    cur_req = "R10"; wr(1'b0, 1, 32'hAABB_CC03, 4'b0001); rd(1'b0, 1);
    wr(1'b0, 1, 32'h0000_0900, 4'b0010); rd(1'b0, 1);
    cur_req = "R7"; wr(1'b1, 1, 32'd3); wr(1'b1, 0, 32'h1); // one-shot ns
    idle(15); rd(1'b1, 2); rd(1'b1, 3);
    cur_req = "R9"; wr(1'b0, 0, 32'h0000_0205); idle(4); // IRQ enable off
    wr(1'b0, 0, 32'h0000_0000); rd(1'b0, 2); idle(6); rd(1'b0, 2);
    cur_req = "R1"; bready = 0; wr(1'b0, 2, 32'd9); idle(3); bready = 1; idle(2);
    rready = 0; rd(1'b0, 2); idle(3); rready = 1; idle(2);
    cur_req = "R2"; rd_all();
    idle(4);
    summary();
  end
endmodule